// File: doc/BRIEF.md
# Sector Erase Batch Window Timer

This block belongs to the command path of a NOR-style flash controller. It decides when a batch of sector-erase requests stops growing and the erase begins. The decoder upstream delivers one pulse for each sector-erase command it has accepted, together with the sector index. The first such pulse opens an acceptance window that lasts a programmable number of clock cycles. Each further sector command that arrives while the window is open adds its sector to the queued bitmap and restarts the full window. When the window runs out, a status bit rises, a one-cycle start pulse goes to the erase engine, and the batch is frozen.

While an erase is running, the block turns away every command except erase-suspend. An erase-suspend is passed on to the engine as a one-cycle pulse. A chip-erase strobe that arrives while the block is idle skips the window: erasure starts at once and the window status bit stays low. Any strobe that the block turns away is reported on a one-cycle ignored flag. The erase-done input returns the block to idle and clears the bitmap.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `win_closed_o`, `start_erase_o`, `suspend_o` and `cmd_ignored_o` are 0 and `sector_map_o` is all zeros.
- R2: A sector command in idle opens the window. On the next cycle `sector_map_o` bit `sec_idx_i` is 1 (bit i stands for sector i) and `win_closed_o` is still 0.
- R3: Take the last accepted sector command as sampled at clock edge t, with window length W. `win_closed_o` stays 0 after edges t+1 to t+W-1. After edge t+W it is 1 and `start_erase_o` is 1 for exactly one cycle.
- R4: A sector command accepted while the window is open ORs its bit into `sector_map_o` and restarts the full W-cycle count.
- R5: A sector command sampled on the edge where the window expires is rejected. Its bit is not set, and `cmd_ignored_o` is 1 in the following cycle.
- R6: While `win_closed_o` is 1, sector and chip-erase strobes change neither `sector_map_o` nor `win_closed_o`. Each one raises `cmd_ignored_o` for one cycle and produces no `start_erase_o`.
- R7: An erase-suspend strobe while an erase runs gives a one-cycle `suspend_o` on the next cycle. In idle or during an open window, an erase-suspend strobe is ignored: `suspend_o` stays 0 and `cmd_ignored_o` pulses.
- R8: A chip-erase strobe in idle gives a one-cycle `start_erase_o`. `win_closed_o` stays 0 and `sector_map_o` stays empty. Sector commands are ignored until erase-done. A chip-erase strobe during an open window is ignored.
- R9: `erase_done_i` during an erase clears `sector_map_o` and `win_closed_o` on the next cycle.
- R10: A window length of 0 behaves as a length of 1.
- R11: If chip-erase and a sector command arrive together in idle, chip erase wins and the sector command is flagged as ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_cycles_i | input | CNT_W | Window length in clock cycles |
| sec_cmd_i | input | 1 | Accepted sector-erase command pulse |
| sec_idx_i | input | IDX_W | Sector index of the command |
| suspend_i | input | 1 | Erase-suspend strobe |
| chip_erase_i | input | 1 | Chip-erase strobe |
| erase_done_i | input | 1 | Erase engine finished |
| win_closed_o | output | 1 | Window expired, sector erase running |
| start_erase_o | output | 1 | One-cycle erase start pulse |
| suspend_o | output | 1 | Suspend forwarded to the erase engine |
| cmd_ignored_o | output | 1 | A strobe was rejected last cycle |
| sector_map_o | output | N_SECTORS | Queued sectors |

## Verification
The assertions check every cycle that the status bit and the bitmap stay frozen while an erase runs and no erase-done arrives. They also check that each start pulse lasts one cycle, that a rising status bit always comes with a start pulse, that a suspend is forwarded only from a busy state, and that erase-done clears both the status bit and the bitmap. Only the directed scenarios can show the exact window length, the restart on a second command, the rejection of a command on the expiry edge, the zero-length window and chip-erase precedence, because each of these depends on when a particular strobe arrives.

// File: rtl/sew_pkg.sv
package sew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_SECT   = 2'd2,
    ST_CHIP   = 2'd3
  } sew_state_e;
endpackage

// File: rtl/sew_timer.sv
module sew_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] win_cycles_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  // zero length is clamped to one cycle
  assign load_val = (win_cycles_i == '0) ? ONE : win_cycles_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign expire_o = run_i && (cnt_q == ONE);
endmodule

// File: rtl/sew_sector_map.sv
module sew_sector_map #(
  parameter int N_SECTORS = 16,
  parameter int IDX_W     = (N_SECTORS > 1) ? $clog2(N_SECTORS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 clr_i,
  output logic [N_SECTORS-1:0] map_o
);
  for (genvar i = 0; i < N_SECTORS; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   map_o[i] <= 1'b0;
      else if (clr_i)                                map_o[i] <= 1'b0;
      else if (set_i && (idx_i == IDX_W'(i)))        map_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl
  import sew_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_cmd_i,
  input  logic suspend_i,
  input  logic chip_erase_i,
  input  logic erase_done_i,
  input  logic expire_i,
  output logic load_o,
  output logic run_o,
  output logic map_set_o,
  output logic map_clr_o,
  output logic win_closed_o,
  output logic start_erase_o,
  output logic suspend_o,
  output logic cmd_ignored_o
);
  sew_state_e st_q, st_d;
  logic start_d, susp_d, ign_d;

  always_comb begin
    st_d      = st_q;
    load_o    = 1'b0;
    map_set_o = 1'b0;
    map_clr_o = 1'b0;
    start_d   = 1'b0;
    susp_d    = 1'b0;
    ign_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        ign_d = suspend_i;
        if (chip_erase_i) begin
          st_d    = ST_CHIP;
          start_d = 1'b1;
          ign_d   = suspend_i | sec_cmd_i;
        end else if (sec_cmd_i) begin
          st_d      = ST_WINDOW;
          load_o    = 1'b1;
          map_set_o = 1'b1;
        end
      end
      ST_WINDOW: begin
        ign_d = suspend_i | chip_erase_i;
        if (expire_i) begin
          st_d    = ST_SECT;
          start_d = 1'b1;
          ign_d   = ign_d | sec_cmd_i;
        end else if (sec_cmd_i) begin
          load_o    = 1'b1;
          map_set_o = 1'b1;
        end
      end
      ST_SECT, ST_CHIP: begin
        ign_d  = sec_cmd_i | chip_erase_i;
        susp_d = suspend_i;
        if (erase_done_i) begin
          st_d      = ST_IDLE;
          map_clr_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      start_erase_o <= 1'b0;
      suspend_o     <= 1'b0;
      cmd_ignored_o <= 1'b0;
    end else begin
      st_q          <= st_d;
      start_erase_o <= start_d;
      suspend_o     <= susp_d;
      cmd_ignored_o <= ign_d;
    end
  end

  assign run_o        = (st_q == ST_WINDOW);
  assign win_closed_o = (st_q == ST_SECT);
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
  parameter int N_SECTORS = 16,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = (N_SECTORS > 1) ? $clog2(N_SECTORS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     win_cycles_i,
  input  logic                 sec_cmd_i,
  input  logic [IDX_W-1:0]     sec_idx_i,
  input  logic                 suspend_i,
  input  logic                 chip_erase_i,
  input  logic                 erase_done_i,
  output logic                 win_closed_o,
  output logic                 start_erase_o,
  output logic                 suspend_o,
  output logic                 cmd_ignored_o,
  output logic [N_SECTORS-1:0] sector_map_o
);
  logic load, run, expire, map_set, map_clr;

  sew_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .run_i        (run),
    .win_cycles_i (win_cycles_i),
    .expire_o     (expire)
  );

  sew_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sec_cmd_i     (sec_cmd_i),
    .suspend_i     (suspend_i),
    .chip_erase_i  (chip_erase_i),
    .erase_done_i  (erase_done_i),
    .expire_i      (expire),
    .load_o        (load),
    .run_o         (run),
    .map_set_o     (map_set),
    .map_clr_o     (map_clr),
    .win_closed_o  (win_closed_o),
    .start_erase_o (start_erase_o),
    .suspend_o     (suspend_o),
    .cmd_ignored_o (cmd_ignored_o)
  );

  sew_sector_map #(.N_SECTORS(N_SECTORS), .IDX_W(IDX_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (map_set),
    .idx_i  (sec_idx_i),
    .clr_i  (map_clr),
    .map_o  (sector_map_o)
  );
endmodule

// File: rtl/sew_checker.sv
module sew_checker #(
  parameter int N_SECTORS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 suspend_i,
  input logic                 erase_done_i,
  input logic                 win_closed_o,
  input logic                 start_erase_o,
  input logic                 suspend_o,
  input logic [N_SECTORS-1:0] sector_map_o
);
  logic busy_q;
  // busy tracker from ports: set by a start pulse, cleared by done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            busy_q <= 1'b0;
    else if (start_erase_o) busy_q <= 1'b1;
    else if (erase_done_i)  busy_q <= 1'b0;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_erase_o |=> !start_erase_o);                                    // R3
  AST_CLOSE_WITH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_closed_o) |-> start_erase_o);                               // R3
  AST_CLOSED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_closed_o && !erase_done_i) |=> win_closed_o);                    // R6
  AST_MAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_closed_o && !erase_done_i) |=> $stable(sector_map_o));           // R6
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_closed_o && erase_done_i) |=> (!win_closed_o && sector_map_o == '0)); // R9
  AST_SUSPEND_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !busy_q && !start_erase_o) |=> !suspend_o);             // R7
endmodule

bind sector_erase_window sew_checker #(.N_SECTORS(N_SECTORS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .suspend_i     (suspend_i),
  .erase_done_i  (erase_done_i),
  .win_closed_o  (win_closed_o),
  .start_erase_o (start_erase_o),
  .suspend_o     (suspend_o),
  .sector_map_o  (sector_map_o)
);

// File: tb/sector_erase_window_tb.sv
module sector_erase_window_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int CW = 16;
  localparam int IW = 4;
  localparam int W  = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] win_cycles_i = CW'(W);
  logic          sec_cmd_i = 1'b0;
  logic [IW-1:0] sec_idx_i = '0;
  logic          suspend_i = 1'b0;
  logic          chip_erase_i = 1'b0;
  logic          erase_done_i = 1'b0;
  logic          win_closed_o, start_erase_o, suspend_o, cmd_ignored_o;
  logic [NS-1:0] sector_map_o;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sector_erase_window #(.N_SECTORS(NS), .CNT_W(CW), .IDX_W(IW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic pulse_sec(input int idx);
    sec_cmd_i = 1'b1; sec_idx_i = IW'(idx);
    step();
    sec_cmd_i = 1'b0;
  endtask

  task automatic pulse_chip();
    chip_erase_i = 1'b1; step(); chip_erase_i = 1'b0;
  endtask

  task automatic pulse_susp();
    suspend_i = 1'b1; step(); suspend_i = 1'b0;
  endtask

  task automatic pulse_done();
    erase_done_i = 1'b1; step(); erase_done_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; step(); step();
    chk("R1 closed", win_closed_o, 0);
    chk("R1 map", sector_map_o, 0);
    chk("R1 start", start_erase_o, 0);
    chk("R1 ignored", cmd_ignored_o, 0);
    chk("R1 suspend", suspend_o, 0);
    rst_ni = 1'b1; step();
  endtask

  task automatic t_single();
    pulse_sec(3);
    chk("R2 map", sector_map_o, 32'h8);
    chk("R2 closed", win_closed_o, 0);
    for (int k = 1; k < W; k++) begin
      step();
      chk("R3 open", win_closed_o, 0);
    end
    step();
    chk("R3 closed", win_closed_o, 1);
    chk("R3 start", start_erase_o, 1);
    step();
    chk("R3 start once", start_erase_o, 0);
    pulse_done();
    chk("R9 closed", win_closed_o, 0);
    chk("R9 map", sector_map_o, 0);
  endtask

  task automatic t_restart();
    pulse_sec(1);
    step(); step(); step();
    pulse_sec(6);
    chk("R4 map", sector_map_o, 32'h42);
    for (int k = 1; k < W; k++) begin
      step();
      chk("R4 restarted", win_closed_o, 0);
    end
    step();
    chk("R4 closed", win_closed_o, 1);
    chk("R4 start", start_erase_o, 1);
    pulse_done();
  endtask

  task automatic t_edge();
    pulse_sec(2);
    for (int k = 1; k < W; k++) step();
    pulse_sec(9);
    chk("R5 closed", win_closed_o, 1);
    chk("R5 ignored", cmd_ignored_o, 1);
    chk("R5 map", sector_map_o, 32'h4);
    pulse_done();
  endtask

  task automatic t_locked();
    pulse_sec(0);
    for (int k = 0; k < W; k++) step();
    chk("R6 closed", win_closed_o, 1);
    pulse_sec(5);
    chk("R6 sector ignored", cmd_ignored_o, 1);
    chk("R6 map", sector_map_o, 32'h1);
    pulse_chip();
    chk("R6 chip ignored", cmd_ignored_o, 1);
    chk("R6 no start", start_erase_o, 0);
    chk("R6 still closed", win_closed_o, 1);
    pulse_susp();
    chk("R7 suspend fwd", suspend_o, 1);
    chk("R7 not ignored", cmd_ignored_o, 0);
    step();
    chk("R7 suspend once", suspend_o, 0);
    pulse_done();
    pulse_susp();
    chk("R7 idle suspend", suspend_o, 0);
    chk("R7 idle ignored", cmd_ignored_o, 1);
  endtask

  task automatic t_chip();
    pulse_chip();
    chk("R8 start", start_erase_o, 1);
    chk("R8 closed", win_closed_o, 0);
    chk("R8 map", sector_map_o, 0);
    step();
    chk("R8 start once", start_erase_o, 0);
    pulse_sec(4);
    chk("R8 sector ignored", cmd_ignored_o, 1);
    chk("R8 map kept", sector_map_o, 0);
    pulse_done();
    sec_cmd_i = 1'b1; sec_idx_i = 4'd8; chip_erase_i = 1'b1;
    step();
    sec_cmd_i = 1'b0; chip_erase_i = 1'b0;
    chk("R11 start", start_erase_o, 1);
    chk("R11 ignored", cmd_ignored_o, 1);
    chk("R11 map", sector_map_o, 0);
    pulse_done();
    pulse_sec(1);
    pulse_chip();
    chk("R8 window chip ignored", cmd_ignored_o, 1);
    chk("R8 window no start", start_erase_o, 0);
    for (int k = 2; k < W; k++) step();
    step();
    chk("R8 window closes", win_closed_o, 1);
    pulse_done();
  endtask

  task automatic t_zero();
    win_cycles_i = '0;
    pulse_sec(7);
    chk("R10 open", win_closed_o, 0);
    step();
    chk("R10 closed", win_closed_o, 1);
    chk("R10 start", start_erase_o, 1);
    pulse_done();
    win_cycles_i = CW'(W);
  endtask

  initial begin
    step();
    t_reset();
    t_single();
    t_restart();
    t_edge();
    t_locked();
    t_chip();
    t_zero();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_vec++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule